// File: doc/BRIEF.md
# Oversampled UART Receiver with Switchable Buffering

This block is the receive half of a UART. It takes the serial input pin, a 16x oversampling tick and a few configuration bits. It rebuilds each character and hands it to a host through a register-style read port. Each bit is decided by a majority vote over three samples taken at the middle of the bit. A disagreement among those samples marks the character as noisy. A low first stop bit marks a framing error. Both flags travel with the character.

There are two ways to buffer received characters, and both use the same storage. In single-buffer mode only one character can be waiting. In FIFO mode up to `DEPTH` characters can queue, each stored with its own error bits. In both modes the output is the oldest waiting character. A read strobe, a flush request, a not-empty flag, an interrupt and a DMA request behave the same way in both modes. When a character completes and no slot is free, the character is dropped and a sticky overrun flag is raised.

Top module: `uart_rx_buf`

## Requirements
- R1: Bits arrive least significant first. `wlen` selects the data width: 2'b10 gives 7 bits, 2'b01 gives 9 bits, and any other code gives 8 bits. Data sits right-aligned in `rd_data`, and the unused upper bits read 0.
- R2: The receiver looks for a start bit only while `glb_en` and `rx_en` are both 1. Line activity at any other time stores nothing. Dropping either enable abandons a character that is in progress.
- R3: With `fifo_mode` at 0, `not_empty` rises on the clock edge at which a character completes. It falls on a cycle with `rd_stb` or `flush_req`. A strobe with nothing buffered has no effect.
- R4: With `fifo_mode` at 0, a character that completes while `not_empty` is high and no read happens in that cycle is discarded. `ovr_flag` is set, and the held character with its flags is unchanged.
- R5: With `fifo_mode` at 1, each character is queued with its own flags. `rd_data`, `rd_fe` and `rd_nf` present the oldest entry, and `rd_stb` pops it. `not_empty` stays high until the queue is empty. `flush_req` empties the queue at once and takes priority over a character completing in the same cycle. All three read outputs are 0 when nothing is buffered.
- R6: With `fifo_mode` at 1, the queue holds `DEPTH` entries. A character completing with all entries used and no read in that cycle is discarded and sets `ovr_flag`, and the queued entries are unchanged.
- R7: `ovr_flag` stays set through reads and flushes until a cycle with `ovr_clr`.
- R8: `irq` is high exactly while `not_empty` and `ie_ne` are both 1.
- R9: `dma_req` is high exactly while `not_empty` and `dma_en` are both 1. Each read strobe removes one character.
- R10: Bits are sampled at the 7th, 8th and 9th ticks (counting from 0 at the tick that detects the falling edge) and decided by majority. `rd_nf` is 1 for a character if those three samples disagreed in its start, data or stop bits.
- R11: A first stop bit decided low sets `rd_fe` for that character, and the character is still stored.
- R12: With `two_stop` at 1, a character completes at the middle of the second stop bit. The level of the second stop bit does not affect `rd_fe`.
- R13: A start bit whose majority sample is high is abandoned, nothing is stored, and the receiver goes back to looking for a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| glb_en | input | 1 | Block enable |
| rx_en | input | 1 | Receiver enable |
| fifo_mode | input | 1 | 1 = multi-entry queue, 0 = single buffer |
| wlen | input | 2 | Data width code |
| two_stop | input | 1 | 1 = two stop bits |
| ie_ne | input | 1 | Interrupt enable for data waiting |
| dma_en | input | 1 | DMA request enable |
| rd_stb | input | 1 | Read strobe, pops the oldest character |
| flush_req | input | 1 | Discard all buffered characters |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 9 | Oldest buffered character |
| rd_fe | output | 1 | Framing error of that character |
| rd_nf | output | 1 | Noise flag of that character |
| not_empty | output | 1 | At least one character waiting |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |
| ovr_flag | output | 1 | Sticky overrun |

## Verification
The bench aims at the edge between full and not full in both modes. There it makes sure that an extra character is dropped rather than written over the oldest entry, because a wrong design would either corrupt the data already held or drop the queued entries. It injects one-sample glitches at the middle of start, data and stop bits, and sends a low stop bit, to confirm that the flags belong to the right character and that a frame with an error is still stored. It also sends a runt start pulse and traffic while the receiver is disabled, which a careless edge detector would turn into phantom characters. Its model predicts the exact clock on which each character completes, so completing one sample too early or too late shows up as a mismatch.

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       glb_en,
  input  logic       rx_en,
  input  logic       fifo_mode,
  input  logic [1:0] wlen,
  input  logic       two_stop,
  input  logic       ie_ne,
  input  logic       dma_en,
  input  logic       rd_stb,
  input  logic       flush_req,
  input  logic       ovr_clr,
  output logic [8:0] rd_data,
  output logic       rd_fe,
  output logic       rd_nf,
  output logic       not_empty,
  output logic       irq,
  output logic       dma_req,
  output logic       ovr_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic rx_m, rxs;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rxs  <= 1'b1;
    end else begin
      rx_m <= rxd;
      rxs  <= rx_m;
    end
  end

  wire active = glb_en & rx_en;

  logic [3:0] nbits;
  always_comb begin
    case (wlen)
      2'b01:   nbits = 4'd9;
      2'b10:   nbits = 4'd7;
      default: nbits = 4'd8;
    endcase
  end

  st_t        st;
  logic [3:0] cnt, bitn;
  logic [1:0] smp;
  logic [8:0] shreg;
  logic       nz, fe1, stop2nd;

  wire maj = (smp[0] & smp[1]) | (smp[0] & rxs) | (smp[1] & rxs);
  wire dis = ~((smp[0] == smp[1]) && (smp[1] == rxs));
  wire at_mid   = os_tick & active & (cnt == 4'd9);
  wire chr_done = at_mid & (st == S_STOP) & (stop2nd | ~two_stop);
  wire c_fe = stop2nd ? fe1 : ~maj;
  wire c_nf = nz | dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; smp <= '0;
      shreg <= '0; nz <= 1'b0; fe1 <= 1'b0; stop2nd <= 1'b0;
    end else if (!active) begin
      st <= S_IDLE;
    end else if (os_tick) begin
      if (st == S_IDLE) begin
        if (!rxs) begin
          st  <= S_START;
          cnt <= 4'd1;
        end
      end else begin
        cnt <= cnt + 4'd1;
        if (cnt == 4'd7) smp[0] <= rxs;
        if (cnt == 4'd8) smp[1] <= rxs;
        if (cnt == 4'd9) begin
          case (st)
            S_START: begin
              if (maj) st <= S_IDLE;
              else begin
                st <= S_DATA; bitn <= '0; nz <= dis; shreg <= '0;
              end
            end
            S_DATA: begin
              shreg[bitn] <= maj;
              nz <= nz | dis;
              bitn <= bitn + 4'd1;
              if (bitn == nbits - 4'd1) begin
                st <= S_STOP; stop2nd <= 1'b0;
              end
            end
            default: begin
              nz <= nz | dis;
              if (!stop2nd) fe1 <= ~maj;
              if (stop2nd || !two_stop) st <= S_IDLE;
              else stop2nd <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] occ;

  wire [CW-1:0] cap = fifo_mode ? FULL : ONE;
  wire pop     = rd_stb & (occ != '0);
  wire room    = (occ < cap) | pop;
  wire push    = chr_done & ~flush_req & room;
  wire ovr_set = chr_done & ~flush_req & ~room;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {c_fe, c_nf, shreg};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_req) begin
      wp <= '0; rp <= '0; occ <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_flag <= 1'b0;
    else if (ovr_set) ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end

  wire [10:0] head = mem[rp];
  assign not_empty = (occ != '0);
  assign rd_data   = not_empty ? head[8:0] : 9'd0;
  assign rd_nf     = not_empty & head[9];
  assign rd_fe     = not_empty & head[10];
  assign irq       = not_empty & ie_ne;
  assign dma_req   = not_empty & dma_en;

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);

  p_single_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && chr_done && occ != '0 && !rd_stb && !flush_req)
      |=> (ovr_flag && $stable(occ)));

  p_fifo_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && chr_done && occ == FULL && !rd_stb && !flush_req)
      |=> (ovr_flag && occ == FULL));

  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !not_empty);

  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && occ != '0 && !chr_done && !flush_req) |=> (occ == $past(occ) - ONE));
endmodule

// File: tb/sim_uart_rx_buf.sv
module sim_uart_rx_buf;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic glb_en = 1'b0, rx_en = 1'b0, fifo_mode = 1'b0, two_stop = 1'b0;
  logic [1:0] wlen = 2'b00;
  logic ie_ne = 1'b0, dma_en = 1'b0, rd_stb = 1'b0, flush_req = 1'b0, ovr_clr = 1'b0;
  logic [8:0] rd_data;
  logic rd_fe, rd_nf, not_empty, irq, dma_req, ovr_flag;

  uart_rx_buf #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .glb_en(glb_en),
    .rx_en(rx_en), .fifo_mode(fifo_mode), .wlen(wlen), .two_stop(two_stop),
    .ie_ne(ie_ne), .dma_en(dma_en), .rd_stb(rd_stb), .flush_req(flush_req),
    .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_fe(rd_fe), .rd_nf(rd_nf),
    .not_empty(not_empty), .irq(irq), .dma_req(dma_req), .ovr_flag(ovr_flag));

  int vecs = 0, errs = 0;
  bit fin = 0;
  string cur_req = "R3";
  logic [10:0] q[$];
  logic m_ovr = 1'b0;

  task automatic chk(input string what, input logic [10:0] act, input logic [10:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic ne;
    logic [10:0] hd;
    ne = (q.size() != 0);
    hd = ne ? q[0] : 11'd0;
    chk("R3 not_empty", {10'd0, not_empty}, {10'd0, ne});
    chk("R1 rd_data", {2'd0, rd_data}, {2'd0, hd[8:0]});
    chk("R11 rd_fe", {10'd0, rd_fe}, {10'd0, hd[10]});
    chk("R10 rd_nf", {10'd0, rd_nf}, {10'd0, hd[9]});
    chk("R8 irq", {10'd0, irq}, {10'd0, ne & ie_ne});
    chk("R9 dma_req", {10'd0, dma_req}, {10'd0, ne & dma_en});
    chk("R7 ovr_flag", {10'd0, ovr_flag}, {10'd0, m_ovr});
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) check_all();
  endtask

  task automatic slot(input logic v);
    rxd = v; os_tick = 1'b1; cyc();
    os_tick = 1'b0; repeat (3) cyc();
  endtask

  task automatic model_done(input logic [10:0] ent);
    int cap;
    cap = fifo_mode ? DEPTH : 1;
    if (q.size() >= cap) m_ovr = 1'b1;
    else q.push_back(ent);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit st2,
                      input int g, input bit bad, input bit expect_store);
    int ncell;
    logic [8:0] md;
    logic [10:0] ent;
    ncell = 1 + nb + (st2 ? 2 : 1);
    md = '0;
    for (int i = 0; i < nb; i++) md[i] = d[i];
    ent = {bad, (g >= 0), md};
    for (int n = 0; n < ncell; n++) begin
      logic v;
      if (n == 0) v = 1'b0;
      else if (n <= nb) v = d[n-1];
      else if (n == nb + 1) v = ~bad;
      else v = 1'b1;
      for (int s = 0; s < 16; s++) begin
        if (expect_store && n == ncell - 1 && s == 10) model_done(ent);
        slot((n == g && s == 8) ? ~v : v);
      end
    end
    repeat (20) slot(1'b1);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    if (q.size() != 0) void'(q.pop_front());
    cyc();
    rd_stb = 1'b0;
    cyc();
  endtask

  task automatic do_flush();
    flush_req = 1'b1; q.delete(); cyc(); flush_req = 1'b0; cyc();
  endtask

  task automatic do_clr();
    ovr_clr = 1'b1; m_ovr = 1'b0; cyc(); ovr_clr = 1'b0; cyc();
  endtask

  initial begin
    repeat (4) cyc();
    rst_n = 1'b1;
    cur_req = "R3";
    repeat (4) cyc();
    glb_en = 1'b1; rx_en = 1'b1; ie_ne = 1'b1;
    repeat (10) slot(1'b1);

    cur_req = "R1";
    send(9'h0A5, 8, 0, -1, 0, 1); do_read();
    send(9'h13C, 8, 0, -1, 0, 1); do_read();

    cur_req = "R3";
    send(9'h081, 8, 0, -1, 0, 1); do_read(); do_read();
    send(9'h07E, 8, 0, -1, 0, 1); do_flush();

    cur_req = "R4";
    send(9'h011, 8, 0, -1, 0, 1);
    send(9'h022, 8, 0, -1, 0, 1);
    cur_req = "R7";
    repeat (10) cyc();
    do_read();
    repeat (5) cyc();
    do_clr();

    cur_req = "R8";
    ie_ne = 1'b0;
    send(9'h055, 8, 0, -1, 0, 1);
    ie_ne = 1'b1; cyc(); do_read();

    cur_req = "R5";
    fifo_mode = 1'b1; dma_en = 1'b1;
    send(9'h001, 8, 0, -1, 0, 1);
    send(9'h002, 8, 0, 3, 0, 1);
    send(9'h003, 8, 0, -1, 1, 1);
    cur_req = "R9";
    do_read(); do_read(); do_read(); do_read();

    cur_req = "R6";
    for (int k = 0; k < DEPTH + 1; k++) send(9'(8'h40 + k), 8, 0, -1, 0, 1);
    for (int k = 0; k < DEPTH; k++) do_read();
    do_clr();
    cur_req = "R5";
    send(9'h0F0, 8, 0, -1, 0, 1);
    send(9'h00F, 8, 0, -1, 0, 1);
    do_flush();
    dma_en = 1'b0;

    cur_req = "R10";
    send(9'h0C3, 8, 0, 0, 0, 1);
    send(9'h0C3, 8, 0, 9, 0, 1);
    send(9'h05A, 8, 0, -1, 0, 1);
    do_read(); do_read(); do_read();

    cur_req = "R11";
    send(9'h099, 8, 0, -1, 1, 1);
    send(9'h066, 8, 0, -1, 0, 1);
    do_read(); do_read();

    cur_req = "R12";
    two_stop = 1'b1; wlen = 2'b01;
    send(9'h1A7, 9, 1, -1, 0, 1);
    send(9'h0B4, 9, 1, -1, 1, 1);
    do_read(); do_read();
    two_stop = 1'b0; wlen = 2'b10;
    cur_req = "R1";
    send(9'h0FF, 7, 0, -1, 0, 1);
    do_read();
    wlen = 2'b00;

    cur_req = "R13";
    for (int s = 0; s < 6; s++) slot(1'b0);
    repeat (40) slot(1'b1);
    send(9'h024, 8, 0, -1, 0, 1);
    do_read();

    cur_req = "R2";
    rx_en = 1'b0;
    send(9'h077, 8, 0, -1, 0, 0);
    rx_en = 1'b1; glb_en = 1'b0;
    send(9'h088, 8, 0, -1, 0, 0);
    glb_en = 1'b1;
    repeat (10) slot(1'b1);
    send(9'h033, 8, 0, -1, 0, 1);
    do_read();

    if (!fin) begin
      fin = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      errs++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule